// File: doc/BRIEF.md
# Protected CHR Bank Remapper

This block sits on a cartridge board beside a scanline-counting bank controller. It turns a 13-bit pattern-table address from the picture unit into a 1 KiB CHR bank index and a 10-bit offset within that bank. The layout is fixed:
- The low 4 KiB holds two 2 KiB sprite windows. Each takes its base from one of the controller's two 2 KiB bank registers.
- The high 4 KiB is a single background window.

A copy-protection scheme hides part of the mapping. Every CPU write to the upper half-plus of the address map is kept in a byte latch. A write into the protection window (CPU $6000–$7FFF) also sets a control byte whose bit 5 chooses between two modes. A later CPU read of the same window does not drive the data bus. Instead, that read copies the latch into hidden state:
- In sprite mode, it loads the XOR mask of the first sprite window.
- In background mode, it loads the background bank and a one-bit XOR mask for the second sprite window.

The bank outputs are combinational from the PPU address and the stored state. The bank index wraps modulo the number of 1 KiB banks fitted to the board.

Top module: `chr_guard_remap`

## Requirements
- R1: A CPU write (wr_en high at a clock edge) to an address in $6000–$FFFF stores the data byte in the write latch. Writes below $6000 leave the latch unchanged.
- R2: A CPU write to $6000–$7FFF also stores the byte in the control register. Control bit 5 selects the mode: 0 is sprite mode and 1 is background mode.
- R3: A CPU read of $6000–$7FFF in background mode sets two values from the latch. The background bank becomes latch bits 5:0. The second-window mask becomes latch bit 6 placed at bit 7, so the mask is 0x00 or 0x80.
- R4: A CPU read of $6000–$7FFF in sprite mode loads the first-window mask with the whole 8-bit latch. Reads outside $6000–$7FFF change no hidden state.
- R5: For PPU addresses $0000–$07FF, the raw bank is 2·(((r0_bank AND 0xFE)>>1) XOR maskA) + ppu_addr[10]. For every PPU address, the offset is ppu_addr[9:0].
- R6: For PPU addresses $0800–$0FFF, the raw bank is 2·(((r1_bank AND 0xFE)>>1) XOR maskB) + ppu_addr[10].
- R7: For PPU addresses $1000–$1FFF, the raw bank is 4·(background bank AND 0x3F) + ppu_addr[11:10].
- R8: The side effect of R3 and R4 is applied once per read, on the first cycle rd_en is high. A read held high for several cycles does not apply it again, even if the latch changes meanwhile.
- R9: The output chr_bank is the raw bank modulo CHR_BANKS.
- R10: Reset clears the latch, the control register, both masks and the background bank to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| wr_en | input | 1 | CPU write, one write per clock it is high |
| rd_en | input | 1 | CPU read strobe, level |
| r0_bank | input | 8 | Controller bank register for the first sprite window |
| r1_bank | input | 8 | Controller bank register for the second sprite window |
| ppu_addr | input | 13 | Pattern-table address |
| chr_bank | output | $clog2(CHR_BANKS) | 1 KiB CHR bank index |
| chr_offset | output | 10 | Byte offset inside the bank |

## Verification
Some properties are checked by assertions on every cycle:
- latch and control capture on writes;
- loading of the masks and background bank on a read edge;
- stability of that hidden state in all other cycles;
- the bank index staying below the bank count.

Other behaviour is shown only by the bench's scenarios:
- the full address-to-bank translation in each window, including wrap on a non-power-of-two bank count;
- the single application of a long read after the latch has moved;
- the observable effect of writes below $6000.

// File: rtl/chr_guard_remap.sv
module chr_guard_remap #(
  parameter int CHR_BANKS = 256,
  localparam int BANK_W = (CHR_BANKS > 1) ? $clog2(CHR_BANKS) : 1,
  localparam int RAW_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        r0_bank,
  input  logic [7:0]        r1_bank,
  input  logic [12:0]       ppu_addr,
  output logic [BANK_W-1:0] chr_bank,
  output logic [9:0]        chr_offset
);

  logic [7:0] wlatch, ctrl, mask_a, mask_b;
  logic [5:0] bg_bank;
  logic       rd_q;

  wire in_win   = cpu_addr[15:13] == 3'b011;
  wire in_upper = cpu_addr[15] | (cpu_addr[14] & cpu_addr[13]);
  wire bg_mode  = ctrl[5];
  wire fire     = rd_en & ~rd_q & in_win;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wlatch  <= '0;
      ctrl    <= '0;
      mask_a  <= '0;
      mask_b  <= '0;
      bg_bank <= '0;
      rd_q    <= 1'b0;
    end else begin
      rd_q <= rd_en;
      if (wr_en && in_upper) wlatch <= cpu_wdata;
      if (wr_en && in_win)   ctrl   <= cpu_wdata;
      if (fire) begin
        if (bg_mode) begin
          bg_bank <= wlatch[5:0];
          mask_b  <= {wlatch[6], 7'b0};
        end else begin
          mask_a  <= wlatch;
        end
      end
    end
  end

  logic [RAW_W-1:0] raw;
  always_comb begin
    unique case (ppu_addr[12:11])
      2'b00:   raw = {({1'b0, r0_bank[7:1]} ^ mask_a), ppu_addr[10]};
      2'b01:   raw = {({1'b0, r1_bank[7:1]} ^ mask_b), ppu_addr[10]};
      default: raw = {1'b0, bg_bank, ppu_addr[11:10]};
    endcase
  end

  logic [RAW_W-1:0] wrapped;
  assign wrapped    = RAW_W'(raw % RAW_W'(CHR_BANKS));
  assign chr_bank   = wrapped[BANK_W-1:0];
  assign chr_offset = ppu_addr[9:0];

  AST_LATCH_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && in_upper |=> wlatch == $past(cpu_wdata)); // R1
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && in_upper) |=> $stable(wlatch)); // R1
  AST_CTRL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && in_win |=> ctrl == $past(cpu_wdata)); // R2
  AST_BG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fire && bg_mode |=> bg_bank == $past(wlatch[5:0]) && mask_b == {$past(wlatch[6]), 7'b0} && $stable(mask_a)); // R3
  AST_SPRA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !bg_mode |=> mask_a == $past(wlatch) && $stable(mask_b) && $stable(bg_bank)); // R4
  AST_HIDDEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(mask_a) && $stable(mask_b) && $stable(bg_bank)); // R8
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire); // R8
  AST_BANK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(chr_bank) < CHR_BANKS); // R9

endmodule

// File: tb/chr_guard_remap_tb.sv
module chr_guard_remap_tb;
  localparam int PERIOD = 10;
  localparam int NB = 96;
  localparam int BW = $clog2(NB);

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0] cpu_wdata = 0, r0_bank = 0, r1_bank = 0;
  logic [12:0] ppu_addr = 0;
  logic [BW-1:0] chr_bank;
  logic [9:0] chr_offset;

  chr_guard_remap #(.CHR_BANKS(NB)) u_dut (.*);

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] m_latch = 0, m_ctrl = 0, m_ma = 0, m_mb = 0;
  logic [5:0] m_bg = 0;

  function automatic int exp_bank(logic [12:0] pa, logic [7:0] a, logic [7:0] b);
    int raw;
    if (pa < 13'h0800)      raw = 2 * (((a & 8'hFE) >> 1) ^ m_ma) + pa[10];
    else if (pa < 13'h1000) raw = 2 * (((b & 8'hFE) >> 1) ^ m_mb) + pa[10];
    else                    raw = 4 * (m_bg & 6'h3F) + pa[11:10];
    return raw % NB;
  endfunction

  task automatic check(string req, logic [12:0] pa, logic [7:0] a, logic [7:0] b);
    int e;
    @(negedge clk);
    ppu_addr = pa; r0_bank = a; r1_bank = b;
    #1;
    e = exp_bank(pa, a, b);
    checks++;
    if (int'(chr_bank) != e || chr_offset != pa[9:0]) begin
      fails++;
      $display("FAIL %s pa=%h bank=%0d exp=%0d off=%h exp=%h", req, pa, chr_bank, e, chr_offset, pa[9:0]);
    end
  endtask

  task automatic do_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    if (a >= 16'h6000) m_latch = d;
    if (a >= 16'h6000 && a < 16'h8000) m_ctrl = d;
  endtask

  task automatic do_read(logic [15:0] a);
    @(negedge clk);
    cpu_addr = a; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    @(negedge clk);
    if (a >= 16'h6000 && a < 16'h8000) begin
      if (m_ctrl[5]) begin m_bg = m_latch[5:0]; m_mb = {m_latch[6], 7'b0}; end
      else m_ma = m_latch;
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired: got timeout, expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R10: reset state, all hidden values zero
    check("R10", 13'h0000, 8'h00, 8'h00);
    check("R10", 13'h0800, 8'h00, 8'h00);
    check("R10", 13'h1000, 8'h00, 8'h00);
    // R5 base mapping without mask
    check("R5", 13'h0400, 8'h05, 8'h00);
    // R4: sprite mode mask load
    do_write(16'h6000, 8'h00);
    do_write(16'h6001, 8'h06);
    do_read(16'h6000);
    check("R4", 13'h0000, 8'h08, 8'h00);
    // R3: background mode, latch via $C000
    do_write(16'h6000, 8'h20);
    do_write(16'hC000, 8'h47);
    do_read(16'h7FFF);
    check("R3", 13'h1000, 8'h00, 8'h04);
    check("R7", 13'h1C00, 8'h00, 8'h04);
    // R9: mask B 0x80 pushes raw past bank count
    check("R9", 13'h0C00, 8'h04, 8'h04);
    check("R6", 13'h0800, 8'h00, 8'hFF);
    // R1: write below $6000 does not touch latch
    do_write(16'h5FFF, 8'h3F);
    do_read(16'h6000);
    check("R1", 13'h1400, 8'h00, 8'h00);
    // R4: read outside window has no effect
    do_write(16'hE000, 8'h11);
    do_read(16'h8000);
    check("R4", 13'h1000, 8'h00, 8'h00);
    // R8: long read applies once, with the latch value at its start
    do_write(16'h6000, 8'h00);
    do_write(16'h6000, 8'h03);
    @(negedge clk); cpu_addr = 16'h6000; rd_en = 1;
    @(negedge clk); cpu_addr = 16'h6000; cpu_wdata = 8'h09; wr_en = 1;
    @(negedge clk); wr_en = 0;
    repeat (3) @(negedge clk);
    rd_en = 0;
    m_ma = 8'h03; m_latch = 8'h09; m_ctrl = 8'h09;
    check("R8", 13'h0000, 8'h00, 8'h00);
    // R2: mode bit from window write selects background path
    do_write(16'h7000, 8'h25);
    do_read(16'h6000);
    check("R2", 13'h1800, 8'h00, 8'h00);
    check("R2", 13'h0000, 8'h00, 8'h00);
    // Random mix
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 5);
      logic [15:0] a;
      case (op)
        0: a = 16'h6000 | 16'($urandom_range(0, 16'h1FFF));
        1: a = 16'h8000 | 16'($urandom_range(0, 16'h7FFF));
        2: a = 16'($urandom_range(0, 16'h5FFF));
        default: a = 16'h6000 | 16'($urandom_range(0, 16'h1FFF));
      endcase
      if (op < 3) do_write(a, 8'($urandom));
      else if (op < 5) do_read(a);
      else do_read(16'($urandom_range(0, 16'h5FFF)) | 16'h8000);
      check(i % 3 == 0 ? "R5" : (i % 3 == 1 ? "R6" : "R7"),
            13'($urandom), 8'($urandom), 8'($urandom));
    end
    // R10: reset again clears hidden state
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    m_latch = 0; m_ctrl = 0; m_ma = 0; m_mb = 0; m_bg = 0;
    check("R10", 13'h1FFF, 8'hAA, 8'h55);
    check("R10", 13'h0000, 8'hAA, 8'h55);
    finish_up();
  end
endmodule